// File: doc/BRIEF.md
# Byte-Wide SRAM Write Strobe Sequencer

This block sits between a synchronous host and an asynchronous byte-wide static RAM. The host gives a single-cycle write request with an address, a data byte and a strobe style. The block then drives the RAM's address lines, data driver, chip-select and write-strobe pins through a timed sequence. Each minimum interval comes from a nanosecond parameter and is rounded up to whole periods of the system clock.

Two styles are supported. With the write-strobe style, chip select is held low around a write-strobe pulse. With the chip-select style, the write strobe is held low around a chip-select pulse. The host watches a busy flag and gets a one-cycle done pulse when the full cycle time has passed. A write-protect input makes the block refuse new requests, which it reports with a one-cycle error pulse.

Top module: `sram_write_seq`

## Requirements
- R1: In reset and whenever busy is low, ram_ce_n and ram_we_n are high, ram_dq_oe is low, and done and err are low after reset.
- R2: A request sampled while idle with wp low raises busy in the next cycle. ram_addr and ram_dq_out then show the request's address and data and do not change while busy stays high.
- R3: The style bit is latched at the request. With style 0 (write-strobe controlled), ram_we_n carries the pulse and ram_ce_n is held low around it. With style 1 (chip-select controlled), ram_ce_n carries the pulse and ram_we_n is held low around it.
- R4: The pulse starts (both strobes low) after a setup phase of max(1, ceil(T_ASETUP_NS/CLK_PERIOD_NS)) cycles, counted from the first busy cycle. This is 1 cycle by default.
- R5: Both strobes are low together for exactly max(ceil(T_PULSE_NS/P), ceil(T_DSETUP_NS/P), ceil(T_AVALID_NS/P) minus setup) cycles, where P is CLK_PERIOD_NS. This is 16 cycles by default.
- R6: ram_dq_oe rises in the same cycle the pulse starts. ram_dq_out is stable while ram_dq_oe is high.
- R7: After the pulse ends, ram_dq_oe, ram_addr and the held strobe stay in place for max(1, ceil(T_AHOLD_NS/P), ceil(T_DHOLD_NS/P)) cycles. This is 2 cycles by default.
- R8: busy stays high for max(ceil(T_CYCLE_NS/P), setup + pulse + hold) cycles. This is 20 cycles by default.
- R9: done is high for exactly one cycle, which is the first cycle after busy falls. done is never high at any other time.
- R10: A request sampled while idle with wp high gives err high for exactly one cycle. busy stays low, no strobe toggles and ram_dq_oe stays low.
- R11: A request while busy is ignored. The running cycle's address and data are unchanged and no extra cycle follows.
- R12: A request in the done cycle is accepted, so back-to-back writes have no gap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Single-cycle write request |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| req_style | input | 1 | 0: write-strobe pulse, 1: chip-select pulse |
| wp | input | 1 | Write protect; refuses new requests |
| busy | output | 1 | Write cycle in progress |
| done | output | 1 | One-cycle pulse after the cycle ends |
| err | output | 1 | One-cycle pulse for a refused request |
| ram_addr | output | ADDR_W | RAM address lines |
| ram_dq_out | output | DATA_W | Data for the RAM bus driver |
| ram_dq_oe | output | 1 | Enable of the data bus driver |
| ram_ce_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |

## Verification
The embedded assertions check these rules on every cycle: the pins are quiet while idle, the address holds steady through busy, the data holds steady while driven, the driver turns on at the strobe fall, it is still on when the strobe rises, the pulse is exactly its width, done is single, and write-protected requests are refused. Some behaviours can only be shown by the bench's scenarios, because they need a reference for the expected values. These are that the RAM sees the requested address and data, which strobe carries the pulse for each style, the setup and hold lengths, the total busy length, that a request during busy does not create a cycle, and that a request in the done cycle is accepted.

// File: rtl/sram_write_seq.sv
module sram_write_seq #(
  parameter int ADDR_W        = 15,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_CYCLE_NS    = 100,
  parameter int T_ASETUP_NS   = 0,
  parameter int T_PULSE_NS    = 80,
  parameter int T_AVALID_NS   = 80,
  parameter int T_DSETUP_NS   = 50,
  parameter int T_DHOLD_NS    = 5,
  parameter int T_AHOLD_NS    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_style,
  input  logic              wp,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe,
  output logic              ram_ce_n,
  output logic              ram_we_n
);

  function automatic int cyc(input int ns);
    return (ns + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int C_SU   = max2(1, cyc(T_ASETUP_NS));
  localparam int C_STB  = max2(1, max2(max2(cyc(T_PULSE_NS), cyc(T_DSETUP_NS)),
                                       cyc(T_AVALID_NS) - C_SU));
  localparam int C_HLD  = max2(1, max2(cyc(T_AHOLD_NS), cyc(T_DHOLD_NS)));
  localparam int C_BASE = C_SU + C_STB + C_HLD;
  localparam int C_TOT  = max2(cyc(T_CYCLE_NS), C_BASE);
  localparam int C_REC  = C_TOT - C_BASE;
  localparam int C_MAX  = max2(max2(C_SU, C_STB), max2(C_HLD, C_REC));
  localparam int CW     = $clog2(C_MAX + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_RECOVER
  } state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              sty_q;

  localparam logic [CW-1:0] L_SU  = CW'(C_SU - 1);
  localparam logic [CW-1:0] L_STB = CW'(C_STB - 1);
  localparam logic [CW-1:0] L_HLD = CW'(C_HLD - 1);
  localparam logic [CW-1:0] L_REC = CW'((C_REC > 0) ? C_REC - 1 : 0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      addr_q <= '0;
      data_q <= '0;
      sty_q  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req) begin
            if (wp) begin
              err <= 1'b1;
            end else begin
              addr_q <= req_addr;
              data_q <= req_data;
              sty_q  <= req_style;
              state  <= ST_SETUP;
              cnt    <= L_SU;
            end
          end
        end
        ST_SETUP: begin
          if (cnt == '0) begin
            state <= ST_STROBE;
            cnt   <= L_STB;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            state <= ST_HOLD;
            cnt   <= L_HLD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            if (C_REC > 0) begin
              state <= ST_RECOVER;
              cnt   <= L_REC;
            end else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RECOVER: begin
          if (cnt == '0) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic framed, pulse;
  assign framed = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
  assign pulse  = (state == ST_STROBE);

  assign busy       = (state != ST_IDLE);
  assign ram_addr   = addr_q;
  assign ram_dq_out = data_q;
  assign ram_dq_oe  = (state == ST_STROBE) || (state == ST_HOLD);
  assign ram_we_n   = !(sty_q ? framed : pulse);
  assign ram_ce_n   = !(sty_q ? pulse : framed);

  logic              wr_act;
  logic [CW:0]       wr_len;
  assign wr_act = !ram_ce_n && !ram_we_n;

  always_ff @(posedge clk) begin
    if (!rst_n)      wr_len <= '0;
    else if (wr_act) wr_len <= wr_len + 1'b1;
    else             wr_len <= '0;
  end

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ram_ce_n && ram_we_n && !ram_dq_oe));

  // R2
  addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ram_addr));

  // R5
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_act) |-> (wr_len == (CW+1)'(C_STB)));

  // R6
  oe_at_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> wr_act);

  // R6
  dq_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out));

  // R7
  hold_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_act) |-> ram_dq_oe);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  wp_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req && wp) |=> (err && !busy));

endmodule

// File: tb/sram_write_seq_bench.sv
`timescale 1ns/1ps
module sram_write_seq_bench;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int P  = 5;
  localparam int E_SU   = 1;
  localparam int E_STB  = 16;
  localparam int E_HLD  = 2;
  localparam int E_BUSY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_style = 1'b0, wp = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic busy, done, err, ram_dq_oe, ram_ce_n, ram_we_n;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_dq_out;

  always #2.5 clk = ~clk;

  sram_write_seq u_sram_write_seq (
    .clk(clk), .rst_n(rst_n), .req(req), .req_addr(req_addr),
    .req_data(req_data), .req_style(req_style), .wp(wp),
    .busy(busy), .done(done), .err(err), .ram_addr(ram_addr),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe),
    .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n));

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; logic s; } item_t;
  item_t exp_q[$];

  int checks = 0, errors = 0, done_cnt = 0, sent = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, expv);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic s);
    while (busy) @(negedge clk);
    req = 1'b1; req_addr = a; req_data = d; req_style = s;
    exp_q.push_back('{a: a, d: d, s: s});
    sent++;
    @(negedge clk);
    req = 1'b0;
    chk(busy == 1'b1, "R2", "busy after accept", busy, 1);
    chk(ram_addr == a, "R2", "address driven", ram_addr, a);
  endtask

  // monitor
  logic p_busy = 0, p_wact = 0, p_oe = 0, in_hold = 0, cur_s = 0;
  logic [DW-1:0] p_dq = '0;
  logic [AW-1:0] cur_a = '0;
  int busy_len = 0, wact_len = 0, post_cnt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic wact;
      wact = !ram_ce_n && !ram_we_n;
      if (busy && !p_busy) busy_len = 1;
      else if (busy) busy_len++;

      if (wact && !p_wact) begin
        chk(busy_len == E_SU + 1, "R4", "pulse start offset", busy_len, E_SU + 1);
        chk(ram_dq_oe == 1'b1, "R6", "driver on at fall", ram_dq_oe, 1);
        wact_len = 1;
      end else if (wact) wact_len++;

      if (ram_dq_oe && p_oe)
        chk(ram_dq_out == p_dq, "R6", "data steady", ram_dq_out, p_dq);

      if (in_hold) begin
        if (ram_dq_oe) begin
          post_cnt++;
          chk(ram_addr == cur_a, "R7", "address held", ram_addr, cur_a);
          chk((cur_s ? ram_we_n : ram_ce_n) == 1'b0, "R7", "held strobe low",
              cur_s ? ram_we_n : ram_ce_n, 0);
        end else begin
          chk(post_cnt == E_HLD, "R7", "hold length", post_cnt, E_HLD);
          in_hold = 0;
        end
      end

      if (!wact && p_wact) begin
        item_t it;
        chk(wact_len == E_STB, "R5", "pulse width", wact_len, E_STB);
        if (exp_q.size() == 0) begin
          chk(0, "R11", "unexpected write cycle", ram_addr, 0);
        end else begin
          it = exp_q.pop_front();
          chk(ram_addr == it.a, "R2", "address at strobe rise", ram_addr, it.a);
          chk(ram_dq_out == it.d, "R2", "data at strobe rise", ram_dq_out, it.d);
          if (it.s)
            chk(ram_ce_n && !ram_we_n, "R3", "chip-select style edge",
                {ram_ce_n, ram_we_n}, 2'b10);
          else
            chk(!ram_ce_n && ram_we_n, "R3", "write-strobe style edge",
                {ram_ce_n, ram_we_n}, 2'b01);
          cur_a = it.a; cur_s = it.s;
        end
        chk(ram_dq_oe == 1'b1, "R7", "driver on at rise", ram_dq_oe, 1);
        in_hold = 1; post_cnt = 1;
      end

      if (!busy && p_busy) begin
        chk(busy_len == E_BUSY, "R8", "busy length", busy_len, E_BUSY);
        chk(done == 1'b1, "R9", "done after busy", done, 1);
        done_cnt++;
      end else if (done) begin
        chk(0, "R9", "stray done", done, 0);
      end

      if (!busy)
        chk(ram_ce_n && ram_we_n && !ram_dq_oe, "R1", "idle pins",
            {ram_ce_n, ram_we_n, ram_dq_oe}, 3'b110);

      p_busy = busy; p_wact = wact; p_oe = ram_dq_oe; p_dq = ram_dq_out;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err, "R1", "outputs in reset", {busy, done, err}, 0);
    chk(ram_ce_n && ram_we_n && !ram_dq_oe, "R1", "pins in reset",
        {ram_ce_n, ram_we_n, ram_dq_oe}, 3'b110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err, "R1", "outputs after reset", {busy, done, err}, 0);

    do_write(15'h1234, 8'hA5, 1'b0);
    do_write(15'h7FFF, 8'h00, 1'b1);
    // R12: next call issues in the done cycle
    do_write(15'h0000, 8'hFF, 1'b0);
    chk(done_cnt == 2, "R12", "accepted in done cycle", done_cnt, 2);
    do_write(15'h2AAA, 8'h5A, 1'b1);
    while (busy) @(negedge clk);

    // R10: write protect
    @(negedge clk);
    wp = 1'b1; req = 1'b1; req_addr = 15'h0F0F; req_data = 8'h3C;
    @(negedge clk);
    req = 1'b0;
    chk(err == 1'b1, "R10", "err pulse", err, 1);
    chk(busy == 1'b0, "R10", "busy stays low", busy, 0);
    chk(ram_ce_n && ram_we_n && !ram_dq_oe, "R10", "pins quiet",
        {ram_ce_n, ram_we_n, ram_dq_oe}, 3'b110);
    @(negedge clk);
    chk(err == 1'b0, "R10", "err single", err, 0);
    chk(busy == 1'b0, "R10", "no cycle started", busy, 0);
    wp = 1'b0;

    // R11: request during busy
    do_write(15'h0101, 8'h11, 1'b0);
    repeat (5) @(negedge clk);
    req = 1'b1; req_addr = 15'h7E7E; req_data = 8'hEE; req_style = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R11", "no extra cycle", busy, 0);
    chk(exp_q.size() == 0, "R11", "queue drained", exp_q.size(), 0);
    chk(done_cnt == sent, "R11", "done count", done_cnt, sent);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule